// File: doc/BRIEF.md
# Cyclic Converter Stage Sequencer with Bias Scaling

This block sequences a cyclic analog-to-digital converter. The converter has one amplifier, a sample-and-hold network and two residue networks that take turns. The sequencer moves through one state per clock. There are five conversion states and a closing state. A conversion resolves 8, 10 or 12 bits, and the resolution sets where the sequence starts: fewer bits means leading states are skipped.

In each state the block drives the control lines. These are the sample-and-hold connect, the amplifier output short, the two residue network enables, two decision strobes (one for each half clock), the enable for the closing two-bit flash, and the output update pulse. It also drives a 4-bit bias code in 10% steps. The code steps the amplifier current down as the later bits need less precision.

Top module: `cyc_adc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes the start state of the current `res_sel` and `stage_o` reads 0. The start state is 0 for 12 bits, 1 for 10 bits and 2 for 8 bits.
- R2: Outside reset, the state (`state_o`: 0..4 = conversion states 1..5, 5 = closing state) moves up by one per clock. From 5 it wraps to the start state of the `res_sel` value seen at that edge.
- R3: `res_sel` encodes the resolution: 00 = 8 bits, 01 = 10 bits, 10 or 11 = 12 bits. A conversion lasts 4, 5 or 6 clocks respectively.
- R4: In the first state of a conversion, `sh_conn`, `amp_short` and `out_upd` are 1 and `net_b_en` is 0. In every other state these three are 0 and `net_b_en` is 1. `net_a_en` is always 1.
- R5: `flash2_en` is 1 only in state 5.
- R6: `bias_code` is 10 in state 0, 5 in state 1, 4 in states 2 and 3, and 3 in states 4 and 5.
- R7: A change of `res_sel` in the middle of a conversion has no effect on any output until the next wrap.
- R8: `stage_o` counts the clocks since the conversion started. It is 0 in the first state.
- R9: `dec_ph1` and `dec_ph2` are both 1 in every cycle in which `rst` is low, and both 0 while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_sel | input | 2 | Resolution select |
| state_o | output | 3 | Current state code |
| stage_o | output | 3 | Stage index within the conversion |
| sh_conn | output | 1 | Connect sample-and-hold to the amplifier |
| amp_short | output | 1 | Amplifier output short, used in the first phase |
| net_a_en | output | 1 | Residue network A enable |
| net_b_en | output | 1 | Residue network B enable |
| dec_ph1 | output | 1 | Decision strobe, first half cycle |
| dec_ph2 | output | 1 | Decision strobe, second half cycle |
| flash2_en | output | 1 | Closing two-bit flash enable |
| out_upd | output | 1 | Output register update |
| bias_code | output | 4 | Bias level in 10% steps |

## Verification
The assertions assume that `rst` is held for at least one edge before it is released. Apart from that, they allow `res_sel` to take any value at any edge, including the unused code 11. The stimulus holds reset for a few cycles under each resolution. It then changes `res_sel` at random in the middle of a conversion and adds directed changes just before and just after a wrap. The bench model latches the resolution only at wrap or reset, so the first-state outputs after such a change can be checked directly.

// File: rtl/cyc_adc_seq.sv
module cyc_adc_seq #(
  parameter int ST_W = 3,
  parameter int BW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      res_sel,
  output logic [ST_W-1:0] state_o,
  output logic [ST_W-1:0] stage_o,
  output logic            sh_conn,
  output logic            amp_short,
  output logic            net_a_en,
  output logic            net_b_en,
  output logic            dec_ph1,
  output logic            dec_ph2,
  output logic            flash2_en,
  output logic            out_upd,
  output logic [BW-1:0]   bias_code
);
  localparam logic [ST_W-1:0] FIN = ST_W'(5);

  function automatic logic [ST_W-1:0] start_of(input logic [1:0] r);
    case (r)
      2'b00:   return ST_W'(2);
      2'b01:   return ST_W'(1);
      default: return ST_W'(0);
    endcase
  endfunction

  logic [ST_W-1:0] state_q;
  logic [1:0]      res_q;
  logic            first;

  always_ff @(posedge clk) begin
    if (rst || state_q == FIN) begin
      state_q <= start_of(res_sel);
      res_q   <= res_sel;
    end else begin
      state_q <= state_q + ST_W'(1);
    end
  end

  assign first     = (state_q == start_of(res_q));
  assign state_o   = state_q;
  assign stage_o   = state_q - start_of(res_q);
  assign sh_conn   = first;
  assign amp_short = first;
  assign out_upd   = first;
  assign net_a_en  = 1'b1;
  assign net_b_en  = ~first;
  assign dec_ph1   = ~rst;
  assign dec_ph2   = ~rst;
  assign flash2_en = (state_q == FIN);

  always_comb begin
    case (state_q)
      ST_W'(0):          bias_code = BW'(10);
      ST_W'(1):          bias_code = BW'(5);
      ST_W'(2), ST_W'(3): bias_code = BW'(4);
      default:           bias_code = BW'(3);
    endcase
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    state_q != FIN |=> state_q == $past(state_q) + ST_W'(1));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    flash2_en |=> out_upd && stage_o == '0);
  a_r4_first: assert property (@(posedge clk) disable iff (rst)
    out_upd |-> sh_conn && amp_short && !net_b_en);
  a_r5_flash: assert property (@(posedge clk) disable iff (rst)
    flash2_en |-> !out_upd && net_b_en);
  a_r6_bias_down: assert property (@(posedge clk) disable iff (rst)
    !out_upd |-> bias_code <= $past(bias_code));
  a_r7_hold_res: assert property (@(posedge clk) disable iff (rst)
    !flash2_en |=> $stable(res_q));
  a_r8_stage: assert property (@(posedge clk) disable iff (rst)
    !flash2_en |=> stage_o == $past(stage_o) + ST_W'(1));
endmodule

// File: tb/sim_cyc_adc_seq.sv
module sim_cyc_adc_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] res_sel = 2'b10;
  logic [2:0] state_o, stage_o;
  logic       sh_conn, amp_short, net_a_en, net_b_en, dec_ph1, dec_ph2, flash2_en, out_upd;
  logic [3:0] bias_code;

  int checks = 0, errors = 0;
  int mst, mres;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cyc_adc_seq u0 (.clk, .rst, .res_sel, .state_o, .stage_o, .sh_conn, .amp_short,
    .net_a_en, .net_b_en, .dec_ph1, .dec_ph2, .flash2_en, .out_upd, .bias_code);

  function automatic int start_of(int r);
    return (r == 0) ? 2 : (r == 1) ? 1 : 0;
  endfunction

  function automatic int exp_bias(int s);
    case (s)
      0: return 10;
      1: return 5;
      2, 3: return 4;
      default: return 3;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst || mst == 5) begin
      mst = start_of(int'(res_sel));
      mres = int'(res_sel);
    end else mst++;
    #1;
    begin
      bit f;
      f = (mst == start_of(mres));
      chk("R2 state", int'(state_o), mst);
      chk("R8 stage", int'(stage_o), mst - start_of(mres));
      chk("R4 sh_conn", int'(sh_conn), int'(f));
      chk("R4 amp_short", int'(amp_short), int'(f));
      chk("R4 out_upd", int'(out_upd), int'(f));
      chk("R4 net_b_en", int'(net_b_en), int'(!f));
      chk("R4 net_a_en", int'(net_a_en), 1);
      chk("R5 flash2_en", int'(flash2_en), int'(mst == 5));
      chk("R6 bias", int'(bias_code), exp_bias(mst));
      chk("R9 dec_ph1", int'(dec_ph1), int'(!rst));
      chk("R9 dec_ph2", int'(dec_ph2), int'(!rst));
    end
  endtask

  task automatic period_check(int r, int exp_len);
    int n = 0;
    res_sel = 2'(r);
    while (!(mst == 5)) step();
    step();
    do begin step(); n++; end while (mst != start_of(r));
    chk("R3 period", n, exp_len);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    mst = 0; mres = 2;
    for (int r = 0; r < 4; r++) begin
      rst = 1'b1; res_sel = 2'(r);
      step(); step();
      chk("R1 reset start", int'(state_o), start_of(r));
      chk("R1 reset stage", int'(stage_o), 0);
      rst = 1'b0;
      for (int k = 0; k < 14; k++) step();
    end
    period_check(0, 4);
    period_check(1, 5);
    period_check(2, 6);
    period_check(3, 6);
    res_sel = 2'b10;
    while (mst != 0) step();
    res_sel = 2'b00;
    step(); step();
    chk("R7 mid change ignored", int'(bias_code), 4);
    while (mst != 5) step();
    res_sel = 2'b01;
    step();
    chk("R7 takes effect at wrap", int'(state_o), 1);
    for (int k = 0; k < 800; k++) begin
      if ($urandom_range(3) == 0) res_sel = 2'($urandom_range(3));
      if ($urandom_range(60) == 0) rst = 1'b1;
      else rst = 1'b0;
      step();
    end
    rst = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule